// File: doc/BRIEF.md
# Bounded-Latency Sequence Token Packer

The block turns a stream of literal bytes and match descriptors into a byte-packed, LZ-style sequence stream. The match finder upstream feeds it one command per cycle. A command appends one literal byte, closes the current sequence with a match (offset and length), or ends the stream. For every sequence the block writes a token byte, any literal-length extension bytes, the buffered literals, a two-byte offset, and, for long matches, a fixed two-byte match-length extension.

A literal run that reaches `LIT_CAP` bytes (300 by default) is written out at once without waiting for a match. This bounds the time between a literal entering and its appearance in the output. The packed bytes are split over two byte-wide RAMs, with even bytes in one and odd bytes in the other. A reader therefore gets a whole 16-bit word from one synchronous read port each cycle. The block emits one byte per cycle and holds `in_ready` low while it emits.

Top module: `seq_token_packer`

## Requirements
- R1: The token's high nibble holds the sequence's literal count when that count is below 15. A value of 15 means literal-length extension bytes follow the token.
- R2: For 15 or more literals, the extension bytes add up to count-15. Each byte of value 255 is followed by another extension byte. The last extension byte is below 255 and may be 0.
- R3: For a match, the token's low nibble is length-4 when that value is below 15, so the smallest match is 4 bytes. Otherwise the low nibble is 15 and a two-byte field equal to length-19 (low byte first) follows the offset.
- R4: The bytes of a sequence are written in this order: token, literal-length extension, literals, offset, match-length extension.
- R5: The offset is written as two bytes, low byte first.
- R6: When the pending literal run reaches `LIT_CAP` bytes, that sequence is written at once. Its token low nibble is 0, its offset bytes are 0x00 0x00, and it has no match-length extension.
- R7: An end command writes a final sequence made of the token, any extension bytes and the pending literals, with no offset. `stream_end` is high for exactly one cycle, the cycle after the last byte is written. The next stream then starts again at byte 0.
- R8: Stream byte k is stored in word k/2. Even k appears on `rd_data[15:8]` and odd k on `rd_data[7:0]`. `rd_data` shows the word at `rd_addr` one cycle after the address is applied.
- R9: After reset `in_ready` is 1 and `stream_end` is 0. `in_ready` drops in the cycle after a sequence is triggered and stays low while bytes are written. At most one command strobe may be high in an accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lit_valid | input | 1 | Append `lit_byte` to the pending literal run |
| lit_byte | input | 8 | Literal byte |
| match_valid | input | 1 | Close the sequence with a match |
| match_off | input | 16 | Match distance |
| match_len | input | 16 | Match length, at least 4 |
| fin_valid | input | 1 | End the stream with a literal-only sequence |
| in_ready | output | 1 | Commands are accepted while high |
| rd_addr | input | AW | Word address for read-out |
| rd_data | output | 16 | Word read: even byte high, odd byte low |
| stream_end | output | 1 | One-cycle pulse after the final byte is written |

## Verification
The bench instantiates the block with the default `LIT_CAP` of 300 and `AW` of 9, which gives 1024 bytes of output per stream. With the full cap in place, the forced flush produces a two-byte literal extension (255 then 30). A 270-literal run exercises a terminating zero extension byte. A match length of 1000 exercises the two-byte match extension. Three streams run back to back, so the restart at byte 0 and odd-length final words are both covered.

// File: rtl/seq_token_packer.sv
module seq_token_packer #(
  parameter int LIT_CAP = 300,
  parameter int AW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lit_valid,
  input  logic [7:0]    lit_byte,
  input  logic          match_valid,
  input  logic [15:0]   match_off,
  input  logic [15:0]   match_len,
  input  logic          fin_valid,
  output logic          in_ready,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  output logic          stream_end
);

  localparam int CW = ($clog2(LIT_CAP + 1) < 9) ? 9 : $clog2(LIT_CAP + 1);
  localparam int DEPTH = 1 << AW;
  localparam logic [CW-1:0] C15  = CW'(15);
  localparam logic [CW-1:0] C255 = CW'(255);
  localparam logic [CW-1:0] CAP  = CW'(LIT_CAP);

  typedef enum logic [2:0] {S_IDLE, S_TOK, S_LEXT, S_LIT, S_OFF0, S_OFF1, S_MX0, S_MX1} st_t;
  localparam logic [1:0] K_MATCH = 2'd0, K_FLUSH = 2'd1, K_FIN = 2'd2;

  st_t st, nxt;
  logic [7:0]    lit_mem [LIT_CAP];
  logic [7:0]    ram_a [DEPTH];
  logic [7:0]    ram_b [DEPTH];
  logic [CW-1:0] cnt, idx, rem;
  logic [1:0]    kind;
  logic [15:0]   off_q, mext_q, mx;
  logic [3:0]    mnib_q;
  logic [AW:0]   wptr;
  logic [7:0]    wbyte;
  logic          emitting, last_lit, is_last;
  logic          take_fin, take_match, take_lit;

  assign in_ready   = (st == S_IDLE);
  assign emitting   = (st != S_IDLE);
  assign take_fin   = in_ready && fin_valid;
  assign take_match = in_ready && match_valid && !fin_valid;
  assign take_lit   = in_ready && lit_valid && !match_valid && !fin_valid;
  assign last_lit   = (idx == cnt - 1'b1);
  assign is_last    = (kind == K_FIN) &&
                      ((st == S_TOK && cnt == '0) || (st == S_LIT && last_lit));
  assign mx         = match_len - 16'd4;

  always_comb begin
    case (st)
      S_TOK:   wbyte = {(cnt >= C15) ? 4'hF : cnt[3:0], mnib_q};
      S_LEXT:  wbyte = (rem >= C255) ? 8'hFF : rem[7:0];
      S_LIT:   wbyte = lit_mem[idx];
      S_OFF0:  wbyte = off_q[7:0];
      S_OFF1:  wbyte = off_q[15:8];
      S_MX0:   wbyte = mext_q[7:0];
      S_MX1:   wbyte = mext_q[15:8];
      default: wbyte = 8'h00;
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (take_fin || take_match || (take_lit && cnt == CAP - 1'b1)) nxt = S_TOK;
      S_TOK: begin
        if (cnt >= C15)        nxt = S_LEXT;
        else if (cnt != '0)    nxt = S_LIT;
        else if (kind == K_FIN) nxt = S_IDLE;
        else                   nxt = S_OFF0;
      end
      S_LEXT: if (rem < C255) nxt = S_LIT;
      S_LIT:  if (last_lit) nxt = (kind == K_FIN) ? S_IDLE : S_OFF0;
      S_OFF0: nxt = S_OFF1;
      S_OFF1: nxt = (mnib_q == 4'hF) ? S_MX0 : S_IDLE;
      S_MX0:  nxt = S_MX1;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; rem <= '0; kind <= K_MATCH;
      off_q <= '0; mext_q <= '0; mnib_q <= '0; wptr <= '0; stream_end <= 1'b0;
    end else begin
      st         <= nxt;
      stream_end <= emitting && is_last;
      if (emitting) wptr <= is_last ? '0 : wptr + 1'b1;
      case (st)
        S_IDLE: begin
          rem <= cnt - C15;
          if (take_fin) begin
            kind <= K_FIN; mnib_q <= 4'h0;
          end else if (take_match) begin
            kind   <= K_MATCH;
            off_q  <= match_off;
            mnib_q <= (mx >= 16'd15) ? 4'hF : mx[3:0];
            mext_q <= mx - 16'd15;
          end else if (take_lit) begin
            cnt <= cnt + 1'b1;
            if (cnt == CAP - 1'b1) begin
              kind <= K_FLUSH; off_q <= '0; mnib_q <= 4'h0;
              rem  <= CAP - C15;
            end
          end
        end
        S_LEXT: if (rem >= C255) rem <= rem - C255;
        S_LIT:  idx <= idx + 1'b1;
        default: ;
      endcase
      if (emitting && nxt == S_IDLE) begin
        cnt <= '0; idx <= '0;
      end
    end
  end

  always_ff @(posedge clk)
    if (take_lit) lit_mem[cnt] <= lit_byte;

  always_ff @(posedge clk) begin
    if (emitting) begin
      if (!wptr[0]) ram_a[wptr[AW:1]] <= wbyte;
      else          ram_b[wptr[AW:1]] <= wbyte;
    end
    rd_data <= {ram_a[rd_addr], ram_b[rd_addr]};
  end

  p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> $onehot0({lit_valid, match_valid, fin_valid}));
  p_min_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_match |-> match_len >= 16'd4);
  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (emitting && !is_last) |=> wptr == $past(wptr) + 1'b1);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !emitting |=> $stable(wptr));
  p_end_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stream_end |=> !stream_end);
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stream_end |-> wptr == '0);
  p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);
  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_lit && cnt == CAP - 1'b1) |=> (st == S_TOK) && !in_ready);

endmodule

// File: tb/seq_token_packer_tb.sv
`timescale 1ns/1ps
module seq_token_packer_tb_top;
  localparam int CAP = 300;
  localparam int AW  = 9;
  localparam int KM = 0, KF = 1, KE = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lit_valid = 1'b0, match_valid = 1'b0, fin_valid = 1'b0;
  logic [7:0] lit_byte = '0;
  logic [15:0] match_off = '0, match_len = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic in_ready, stream_end;

  seq_token_packer #(.LIT_CAP(CAP), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lit_valid(lit_valid), .lit_byte(lit_byte),
    .match_valid(match_valid), .match_off(match_off), .match_len(match_len),
    .fin_valid(fin_valid), .in_ready(in_ready), .rd_addr(rd_addr),
    .rd_data(rd_data), .stream_end(stream_end));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit mon_done = 0, finished = 0;
  logic [7:0] exp_q[$];
  logic [7:0] pend_q[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic model_seq(input int kind, input int off, input int len);
    int n = pend_q.size();
    int lo = 0, r;
    if (kind == KM) lo = (len - 4 >= 15) ? 15 : len - 4;
    exp_q.push_back(8'(((n >= 15) ? 15 : n) * 16 + lo));
    if (n >= 15) begin
      r = n - 15;
      while (r >= 255) begin exp_q.push_back(8'hFF); r -= 255; end
      exp_q.push_back(8'(r));
    end
    foreach (pend_q[i]) exp_q.push_back(pend_q[i]);
    if (kind != KE) begin
      exp_q.push_back(8'(off)); exp_q.push_back(8'(off >> 8));
      if (lo == 15) begin
        exp_q.push_back(8'(len - 19)); exp_q.push_back(8'((len - 19) >> 8));
      end
    end
    pend_q.delete();
  endtask

  task automatic wait_ready();
    while (!in_ready) @(negedge clk);
  endtask

  task automatic send_lit(input logic [7:0] b);
    wait_ready();
    lit_valid = 1'b1; lit_byte = b;
    @(negedge clk);
    lit_valid = 1'b0;
    pend_q.push_back(b);
    if (pend_q.size() == CAP) begin
      check(in_ready == 1'b0, "R6 flush starts at cap", in_ready, 0);
      model_seq(KF, 0, 0);
    end
  endtask

  task automatic send_match(input int off, input int len);
    wait_ready();
    match_valid = 1'b1; match_off = 16'(off); match_len = 16'(len);
    @(negedge clk);
    match_valid = 1'b0;
    check(in_ready == 1'b0, "R9 busy while emitting", in_ready, 0);
    model_seq(KM, off, len);
  endtask

  task automatic send_fin();
    wait_ready();
    fin_valid = 1'b1;
    @(negedge clk);
    fin_valid = 1'b0;
    model_seq(KE, 0, 0);
    wait (mon_done);
    mon_done = 0;
  endtask

  task automatic lits(input int n, input int seed);
    for (int i = 0; i < n; i++) send_lit(8'((i * 7 + seed) ^ (i >> 3)));
  endtask

  // monitor: on each stream end, read back and pop expected bytes (R4, R8, R7)
  initial begin
    forever begin
      @(negedge clk);
      if (stream_end) begin
        int n = exp_q.size();
        for (int w = 0; w < (n + 1) / 2; w++) begin
          rd_addr = AW'(w);
          @(negedge clk);
          if (w == 0) check(stream_end == 1'b0, "R7 end is one pulse", stream_end, 0);
          check(rd_data[15:8] == exp_q[2*w], "R8 even byte", rd_data[15:8], exp_q[2*w]);
          if (2*w + 1 < n)
            check(rd_data[7:0] == exp_q[2*w+1], "R8 odd byte", rd_data[7:0], exp_q[2*w+1]);
        end
        exp_q.delete();
        mon_done = 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R9 ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
    check(stream_end == 1'b0, "R9 no end after reset", stream_end, 0);
    // stream 1: short run (R1, R5), 20 literals with len 19 (R2, R3), final of 2 (R7)
    lits(3, 1);   send_match(16'h1234, 4);
    lits(20, 9);  send_match(5, 19);
    lits(2, 40);  send_fin();
    // stream 2: zero literals, then cap flush (R6), empty final (R7)
    send_match(16'h0100, 7);
    lits(CAP, 3);
    send_fin();
    // stream 3: 270 literals -> 255,0 extension (R2), long match (R3), 16-literal final
    lits(270, 77); send_match(16'hABCD, 1000);
    lits(16, 5);   send_fin();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule